// File: doc/BRIEF.md
# Parity-Guarded Shared Queue Memory

This block wraps one single-port synchronous memory that holds the queue configuration words and the queue buffers of a hardware queue manager. The array has 2048 words; each stored word carries 32 data bits and 4 parity bits, one per byte lane. The lowest 64 words hold configuration words and the rest is buffer space. The wrapper does not enforce this split: both clients may read and write any word.

Two clients share the one physical port. The queue-control side drives word addresses directly and always wins. The bus side presents byte addresses, and an address window starting at byte 0x2000 is mapped onto the array. When both sides ask in the same cycle, the bus side is held off by its grant signal until the port is free.

Parity is generated on every write and checked on every read. While reporting is enabled, a mismatch latches a sticky error flag, which drives the `parityErr` output. Reporting is off after reset, so software can fill the array before any check counts. A small configuration word enables reporting, clears the flag, and lets a diagnostic mode store deliberately inverted parity.

Top module: `qmem_guard`

## Requirements
- R1: The queue port can write and read every word address 0 to 2047. A read request (`qReq`=1, `qWe`=0) returns the stored data on `qRdata`, with `qRvalid` high, exactly one cycle after the cycle of the request.
- R2: A bus byte address A with 0x2000 <= A < 0x4000 selects word (A-0x2000)/4 of the same array the queue port uses. Bus reads return data with `bRvalid` high one cycle after the granted cycle.
- R3: When `qReq` and an in-window `bReq` are both high, the queue access is performed and `bGnt` is 0. The bus request is performed in the first cycle it is asserted without `qReq`.
- R4: A bus request outside the window is granted in the same cycle and never touches the array. Such a write is discarded. Such a read returns all-zero data with `bRvalid` one cycle later.
- R5: Each write stores four even-parity bits, one per byte lane of the data. With reporting enabled, reading words written in normal mode never sets the error flag, whatever the data pattern.
- R6: With reporting enabled, a read from either port of a word whose stored parity does not match still returns its data. It sets `parityErr` at the clock edge that ends the cycle in which that read data is valid.
- R7: While reporting is disabled, parity mismatches do not set `parityErr`.
- R8: `parityErr` is sticky. It stays high until a configuration write (`cfgWe`=1) has bit 1 of `cfgWdata` set. A configuration write with bit 1 clear leaves the flag unchanged. Bit 0 of every configuration write sets the reporting enable, which is readable on `reportEn`.
- R9: If a clear is written in the same cycle that a reported mismatch is detected, the flag ends up set.
- R10: Bit 2 of the configuration word selects diagnostic writes. While it is 1, every write stores all four parity bits inverted.
- R11: After reset, `parityErr`, `reportEn`, `qRvalid` and `bRvalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| qReq | input | 1 | Queue-control access request |
| qWe | input | 1 | Queue access is a write |
| qAddr | input | 11 | Queue word address |
| qWdata | input | 32 | Queue write data |
| qRdata | output | 32 | Queue read data |
| qRvalid | output | 1 | Queue read data valid |
| bReq | input | 1 | Bus access request, held until granted |
| bWe | input | 1 | Bus access is a write |
| bAddr | input | 15 | Bus byte address |
| bWdata | input | 32 | Bus write data |
| bGnt | output | 1 | Bus request accepted this cycle |
| bRdata | output | 32 | Bus read data |
| bRvalid | output | 1 | Bus read data valid |
| cfgWe | input | 1 | Configuration word write strobe |
| cfgWdata | input | 3 | Bit 0 report enable, bit 1 clear flag, bit 2 invert parity |
| reportEn | output | 1 | Current reporting enable |
| parityErr | output | 1 | Sticky parity error flag |

## Verification
The bench uses the default parameters: 11 address bits, 32 data bits in 8-bit lanes, and a bus window at byte 0x2000. These put the top word 2047 and both window edges, 0x1FFC and 0x4000, within reach of short directed tests. They also keep the 2048-word model small enough to track every write. The diagnostic parity inversion lets the bench plant corrupt words on demand. With a single clock-accurate stall scenario, the bench can show that a queue write made while the bus is held off is visible to the bus read that follows.

// File: rtl/qmem_pkg.sv
package qmem_pkg;

  // Strobes from control to datapath for one memory cycle
  typedef struct packed {
    logic memEn;    // array access this cycle
    logic memWe;    // access is a write
    logic flipPar;  // store inverted parity
    logic rdQ;      // queue read issued
    logic rdB;      // bus read issued to array
    logic rdOob;    // bus read outside window
  } memStrobe_t;

  localparam int CFG_W      = 3;
  localparam int CFG_ENABLE = 0;
  localparam int CFG_CLEAR  = 1;
  localparam int CFG_FLIP   = 2;

endpackage

// File: rtl/qmem_dpath.sv
module qmem_dpath
  import qmem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] qRdata,
  output logic              qRvalid,
  output logic [DATA_W-1:0] bRdata,
  output logic              bRvalid,
  output logic              parFail
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NPAR   = DATA_W / LANE_W;
  localparam int WORD_W = DATA_W + NPAR;

  logic [WORD_W-1:0] memArr [DEPTH];
  logic [WORD_W-1:0] rdWord;
  logic [NPAR-1:0]   wrPar;
  logic [NPAR-1:0]   chkPar;
  logic              rdQReg;
  logic              rdBReg;
  logic              rdOobReg;

  // Even parity per byte lane, for both the write and the read word
  for (genvar i = 0; i < NPAR; i++) begin : g_lane
    assign wrPar[i]  = ^wdata[i*LANE_W +: LANE_W];
    assign chkPar[i] = ^rdWord[i*LANE_W +: LANE_W];
  end

  // Single-port synchronous array
  always_ff @(posedge clk) begin
    if (stb.memEn) begin
      if (stb.memWe) begin
        memArr[addr] <= {wrPar ^ {NPAR{stb.flipPar}}, wdata};
      end else begin
        rdWord <= memArr[addr];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQReg   <= 1'b0;
      rdBReg   <= 1'b0;
      rdOobReg <= 1'b0;
    end else begin
      rdQReg   <= stb.rdQ;
      rdBReg   <= stb.rdB;
      rdOobReg <= stb.rdOob;
    end
  end

  assign qRdata  = rdWord[DATA_W-1:0];
  assign qRvalid = rdQReg;
  assign bRdata  = rdOobReg ? '0 : rdWord[DATA_W-1:0];
  assign bRvalid = rdBReg | rdOobReg;
  assign parFail = (rdQReg | rdBReg) & (chkPar != rdWord[WORD_W-1:DATA_W]);

endmodule

// File: rtl/qmem_ctrl.sv
module qmem_ctrl
  import qmem_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 32,
  parameter int BUS_AW   = 15,
  parameter int BUS_BASE = 'h2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              qReq,
  input  logic              qWe,
  input  logic [ADDR_W-1:0] qAddr,
  input  logic [DATA_W-1:0] qWdata,
  input  logic              bReq,
  input  logic              bWe,
  input  logic [BUS_AW-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWdata,
  input  logic              parFail,
  output memStrobe_t        stb,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              bGnt,
  output logic              reportEn,
  output logic              parityErr
);

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int WORD_B    = DATA_W / 8;
  localparam int BSH       = $clog2(WORD_B);
  localparam int WIN_BYTES = DEPTH * WORD_B;

  logic [31:0]       bFull;
  logic [31:0]       bOffset;
  logic              inWin;
  logic              bToArray;
  logic [ADDR_W-1:0] bWord;
  logic              flipReg;

  // Bus window decode
  assign bFull    = 32'(bAddr);
  assign bOffset  = bFull - 32'(BUS_BASE);
  assign inWin    = (bFull >= 32'(BUS_BASE)) && (bFull < 32'(BUS_BASE + WIN_BYTES));
  assign bWord    = bOffset[BSH +: ADDR_W];

  // Fixed priority: queue side first, out-of-window bus needs no port
  assign bToArray = bReq & inWin & ~qReq;
  assign bGnt     = bReq & (~inWin | ~qReq);

  always_comb begin
    stb.memEn   = qReq | bToArray;
    stb.memWe   = qReq ? qWe : bWe;
    stb.flipPar = flipReg;
    stb.rdQ     = qReq & ~qWe;
    stb.rdB     = bToArray & ~bWe;
    stb.rdOob   = bReq & ~inWin & ~bWe;
    memAddr     = qReq ? qAddr : bWord;
    memWdata    = qReq ? qWdata : bWdata;
  end

  // Configuration word and sticky flag; a new error beats a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reportEn  <= 1'b0;
      flipReg   <= 1'b0;
      parityErr <= 1'b0;
    end else begin
      if (cfgWe) begin
        reportEn <= cfgWdata[CFG_ENABLE];
        flipReg  <= cfgWdata[CFG_FLIP];
      end
      if (parFail && reportEn) begin
        parityErr <= 1'b1;
      end else if (cfgWe && cfgWdata[CFG_CLEAR]) begin
        parityErr <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/qmem_guard.sv
module qmem_guard
  import qmem_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 32,
  parameter int LANE_W   = 8,
  parameter int BUS_AW   = 15,
  parameter int BUS_BASE = 'h2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              qReq,
  input  logic              qWe,
  input  logic [ADDR_W-1:0] qAddr,
  input  logic [DATA_W-1:0] qWdata,
  output logic [DATA_W-1:0] qRdata,
  output logic              qRvalid,
  input  logic              bReq,
  input  logic              bWe,
  input  logic [BUS_AW-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic              bGnt,
  output logic [DATA_W-1:0] bRdata,
  output logic              bRvalid,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWdata,
  output logic              reportEn,
  output logic              parityErr
);

  memStrobe_t        stb;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic              parFail;

  qmem_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_AW(BUS_AW), .BUS_BASE(BUS_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .qReq(qReq), .qWe(qWe), .qAddr(qAddr), .qWdata(qWdata),
    .bReq(bReq), .bWe(bWe), .bAddr(bAddr), .bWdata(bWdata),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .parFail(parFail),
    .stb(stb), .memAddr(memAddr), .memWdata(memWdata),
    .bGnt(bGnt), .reportEn(reportEn), .parityErr(parityErr)
  );

  qmem_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(memAddr), .wdata(memWdata),
    .qRdata(qRdata), .qRvalid(qRvalid), .bRdata(bRdata), .bRvalid(bRvalid),
    .parFail(parFail)
  );

endmodule

// File: rtl/qmem_guard_chk.sv
module qmem_guard_chk #(
  parameter int DATA_W   = 32,
  parameter int BUS_AW   = 15,
  parameter int BUS_BASE = 'h2000,
  parameter int WIN_END  = 'h4000
) (
  input logic              clk,
  input logic              rstN,
  input logic              qReq,
  input logic              qWe,
  input logic              bReq,
  input logic              bWe,
  input logic [BUS_AW-1:0] bAddr,
  input logic              bGnt,
  input logic [DATA_W-1:0] bRdata,
  input logic              bRvalid,
  input logic              qRvalid,
  input logic              cfgWe,
  input logic [2:0]        cfgWdata,
  input logic              reportEn,
  input logic              parityErr
);

  logic hit;
  assign hit = (32'(bAddr) >= 32'(BUS_BASE)) && (32'(bAddr) < 32'(WIN_END));

  a_r1_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    qReq && !qWe |=> qRvalid);

  a_r3_queue_first: assert property (@(posedge clk) disable iff (!rstN)
    qReq && bReq && hit |-> !bGnt);

  a_r4_oob_grant: assert property (@(posedge clk) disable iff (!rstN)
    bReq && !hit |-> bGnt);

  a_r4_oob_zero: assert property (@(posedge clk) disable iff (!rstN)
    bReq && !hit && !bWe |=> bRvalid && (bRdata == '0));

  a_r6_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> $past(qRvalid || bRvalid));

  a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> $past(reportEn));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    parityErr && !(cfgWe && cfgWdata[1]) |=> parityErr);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe && cfgWdata[1] && !qRvalid && !bRvalid |=> !parityErr);

endmodule

bind qmem_guard qmem_guard_chk #(
  .DATA_W(DATA_W), .BUS_AW(BUS_AW), .BUS_BASE(BUS_BASE),
  .WIN_END(BUS_BASE + (1 << ADDR_W) * (DATA_W / 8))
) u_chk (
  .clk(clk), .rstN(rstN), .qReq(qReq), .qWe(qWe), .bReq(bReq), .bWe(bWe),
  .bAddr(bAddr), .bGnt(bGnt), .bRdata(bRdata), .bRvalid(bRvalid),
  .qRvalid(qRvalid), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
  .reportEn(reportEn), .parityErr(parityErr)
);

// File: tb/sim_qmem_guard.sv
module sim_qmem_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        qReq = 0, qWe = 0;
  logic [10:0] qAddr = '0;
  logic [31:0] qWdata = '0;
  logic [31:0] qRdata;
  logic        qRvalid;
  logic        bReq = 0, bWe = 0;
  logic [14:0] bAddr = '0;
  logic [31:0] bWdata = '0;
  logic        bGnt;
  logic [31:0] bRdata;
  logic        bRvalid;
  logic        cfgWe = 0;
  logic [2:0]  cfgWdata = '0;
  logic        reportEn;
  logic        parityErr;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] qExp[$];
  logic [31:0] bExp[$];

  always #2 clk = ~clk;

  qmem_guard u0 (
    .clk(clk), .rstN(rstN),
    .qReq(qReq), .qWe(qWe), .qAddr(qAddr), .qWdata(qWdata),
    .qRdata(qRdata), .qRvalid(qRvalid),
    .bReq(bReq), .bWe(bWe), .bAddr(bAddr), .bWdata(bWdata),
    .bGnt(bGnt), .bRdata(bRdata), .bRvalid(bRvalid),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .reportEn(reportEn), .parityErr(parityErr)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pop expected read data as results appear
  always @(negedge clk) begin
    if (rstN && qRvalid) begin
      if (qExp.size() == 0) check(1'b0, "R1 unexpected qRvalid", qRdata, '0);
      else begin
        automatic logic [31:0] e = qExp.pop_front();
        check(qRdata === e, "R1 queue read data", qRdata, e);
      end
    end
    if (rstN && bRvalid) begin
      if (bExp.size() == 0) check(1'b0, "R2 unexpected bRvalid", bRdata, '0);
      else begin
        automatic logic [31:0] e = bExp.pop_front();
        check(bRdata === e, "R2 bus read data", bRdata, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic qWrite(input logic [10:0] a, input logic [31:0] d);
    qReq = 1; qWe = 1; qAddr = a; qWdata = d;
    tick();
    qReq = 0; qWe = 0;
  endtask

  task automatic qRead(input logic [10:0] a, input logic [31:0] e);
    qReq = 1; qWe = 0; qAddr = a; qExp.push_back(e);
    tick();
    qReq = 0;
  endtask

  task automatic bAccess(input logic we, input logic [14:0] a, input logic [31:0] d);
    bReq = 1; bWe = we; bAddr = a; bWdata = d;
    forever begin
      @(negedge clk);
      if (bGnt) break;
    end
    tick();
    bReq = 0; bWe = 0;
  endtask

  task automatic bRead(input logic [14:0] a, input logic [31:0] e);
    bExp.push_back(e);
    bAccess(1'b0, a, '0);
  endtask

  task automatic cfgWrite(input logic [2:0] v);
    cfgWe = 1; cfgWdata = v;
    tick();
    cfgWe = 0;
  endtask

  task automatic finishRun();
    repeat (3) tick();
    check(qExp.size() == 0 && bExp.size() == 0, "R1 pending reads", 32'(qExp.size() + bExp.size()), 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #800000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R11 reset state
    check(parityErr == 0, "R11 parityErr after reset", 32'(parityErr), 0);
    check(reportEn == 0, "R11 reportEn after reset", 32'(reportEn), 0);
    check(!qRvalid && !bRvalid, "R11 valids after reset", {qRvalid, bRvalid}, 0);

    // R1 whole-array queue access, configuration area and buffer space
    qWrite(11'd0, 32'hA5A5_0001);
    qWrite(11'd63, 32'h0000_0000);
    qWrite(11'd64, 32'hFFFF_FFFF);
    qWrite(11'd2047, 32'h1357_9BDF);
    qRead(11'd0, 32'hA5A5_0001);
    qRead(11'd63, 32'h0000_0000);
    qRead(11'd64, 32'hFFFF_FFFF);
    qRead(11'd2047, 32'h1357_9BDF);
    // R1 latency: valid must drop in the cycle after the last result
    tick();
    check(!qRvalid, "R1 qRvalid single cycle", 32'(qRvalid), 0);

    // R2 bus window maps onto same words
    bAccess(1'b1, 15'h2000 + 15'd4 * 15'd5, 32'hCAFE_0005);
    qRead(11'd5, 32'hCAFE_0005);
    bRead(15'h2000 + 15'd4 * 15'd2047, 32'h1357_9BDF);
    bRead(15'h2003, 32'hA5A5_0001);

    // R4 out-of-window requests
    bAccess(1'b1, 15'h1FFC, 32'hDEAD_BEEF);
    bAccess(1'b1, 15'h4000, 32'hDEAD_BEEF);
    bRead(15'h1FFC, 32'h0);
    bRead(15'h4000, 32'h0);
    qRead(11'd2047, 32'h1357_9BDF);
    qRead(11'd0, 32'hA5A5_0001);

    // R3 queue first; queue write during stall is seen by bus read
    qWrite(11'd9, 32'h1111_1111);
    tick();
    bExp.push_back(32'h2222_2222);
    bReq = 1; bWe = 0; bAddr = 15'h2000 + 15'd36;
    qReq = 1; qWe = 1; qAddr = 11'd9; qWdata = 32'h2222_2222;
    @(negedge clk);
    check(bGnt == 0, "R3 bus held while queue active", 32'(bGnt), 0);
    tick();
    qWe = 0; qAddr = 11'd64; qExp.push_back(32'hFFFF_FFFF);
    @(negedge clk);
    check(bGnt == 0, "R3 bus held second cycle", 32'(bGnt), 0);
    tick();
    qReq = 0;
    @(negedge clk);
    check(bGnt == 1, "R3 bus granted when queue idle", 32'(bGnt), 1);
    tick();
    bReq = 0;

    // R10 plant bad parity, R7 not reported while disabled
    cfgWrite(3'b100);
    qWrite(11'd100, 32'h1234_5678);
    cfgWrite(3'b000);
    qRead(11'd100, 32'h1234_5678);
    repeat (2) tick();
    check(parityErr == 0, "R7 no report when disabled", 32'(parityErr), 0);

    // R6 reported mismatch
    cfgWrite(3'b001);
    check(reportEn == 1, "R8 reportEn written", 32'(reportEn), 1);
    qRead(11'd100, 32'h1234_5678);
    check(parityErr == 0, "R6 flag not yet set in data cycle", 32'(parityErr), 0);
    tick();
    check(parityErr == 1, "R6 flag set after queue read", 32'(parityErr), 1);

    // R8 sticky
    repeat (5) tick();
    check(parityErr == 1, "R8 flag holds", 32'(parityErr), 1);
    cfgWrite(3'b001);
    check(parityErr == 1, "R8 write without clear bit", 32'(parityErr), 1);
    cfgWrite(3'b011);
    check(parityErr == 0, "R8 clear by write one", 32'(parityErr), 0);

    // R9 set beats clear in same cycle
    qRead(11'd100, 32'h1234_5678);
    cfgWrite(3'b011);
    check(parityErr == 1, "R9 set wins over clear", 32'(parityErr), 1);
    cfgWrite(3'b011);
    check(parityErr == 0, "R9 clear afterwards", 32'(parityErr), 0);

    // R6 via bus port
    bRead(15'h2000 + 15'd400, 32'h1234_5678);
    tick();
    check(parityErr == 1, "R6 flag set after bus read", 32'(parityErr), 1);
    cfgWrite(3'b011);

    // R5 normal writes never flag, varied patterns per lane
    qWrite(11'd100, 32'h1234_5678);
    for (int i = 0; i < 16; i++) begin
      qWrite(11'(200 + i), 32'h0101_0101 << i ^ 32'(i * 32'h0703_0B01));
    end
    for (int i = 0; i < 16; i++) begin
      qRead(11'(200 + i), 32'h0101_0101 << i ^ 32'(i * 32'h0703_0B01));
    end
    qRead(11'd100, 32'h1234_5678);
    repeat (2) tick();
    check(parityErr == 0, "R5 good parity never flags", 32'(parityErr), 0);

    finishRun();
  end

endmodule